// File: doc/BRIEF.md
# Serial Flash Controller Host Register and FIFO Front End

This block sits between a simple 32-bit register bus and the serial sequencer of a flash controller. Software configures the controller through a settings register, describes each transfer in a frame descriptor, watches a status word and selects interrupt sources through an enable mask. Outgoing bytes enter a 16-entry transmit byte queue that the sequencer drains one byte at a time. Incoming bytes enter a 16-entry receive byte queue that software drains.

Both data queues can be reached through byte-wide ports or through 4-byte packed ports. The packed ports work only while the packing bit in the settings register is set, and only when the queue has room for, or holds, a full word. Otherwise the access leaves the queue unchanged. Three event flags stay set until software writes 1 to them. The interrupt output combines the enabled status bits. Writing the frame descriptor sends a one-cycle start pulse to the sequencer.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the settings, enable mask, descriptor and upper-count registers read 0, both queues are empty, `irq` is 0 and `frame_start` is 0.
- R2: Register offsets are: settings 0x00, descriptor 0x04, enable mask 0x0C, status 0x10, byte receive 0x40, byte transmit 0x44, packed receive 0x48, packed transmit 0x4C, upper count 0x50. The settings register keeps bit 0 (enable), bit 1 (master), bit 16 (packing) and bits 27:24 (clock rate), and other bits read 0. The enable mask keeps bits 5:0. The upper-count register keeps bits 31:16. The descriptor keeps every bit except bit 30. Each kept field drives its output port.
- R3: Descriptor fields are total-count low half in 15:0, command bytes in 24:16, multi-lane in 25, idle cycles in 29:26 and word flag in 31. `total_bytes` is the upper count's bits 31:16 joined with the descriptor's bits 15:0. A descriptor write raises `frame_start` for exactly the cycle after the write.
- R4: A write to 0x44 queues wdata[7:0] as one transmit byte, or is dropped when the transmit queue is full. `tx_byte` shows the oldest queued byte, `tx_empty` flags an empty queue, and `tx_pop` removes one byte.
- R5: A write to 0x4C with packing set and at least 4 free transmit entries queues four bytes, wdata[7:0] first. If packing is clear or fewer than 4 entries are free, the write is dropped.
- R6: A read of 0x40 returns the oldest receive byte in rdata[7:0], with upper bits 0, and removes it. An empty receive queue returns 0.
- R7: A read of 0x48 with packing set and at least 4 entries queued returns four bytes, the oldest in bits 7:0, and removes them. Otherwise it returns 0 and removes nothing.
- R8: The status word holds live bits: bit 3 transmit queue not full, bit 4 receive queue empty, bit 5 transmit queue full, bit 7 the `seq_ready` input and bit 8 the packing bit. Bit 6 reads 0.
- R9: Status bit 0 is set by `seq_tx_done`. Bit 1 is set by an accepted receive byte marked `rx_last`. Bit 2 is set by any accepted receive byte. A status write of 1 to one of these bits clears it, and a set in the same cycle takes priority.
- R10: `irq` is high exactly when some status bit among 5:0 is 1 and its enable-mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops data ports) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| tx_pop | input | 1 | Sequencer takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Sequencer delivers one receive byte |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last returned byte of the frame |
| rx_full | output | 1 | Receive queue full |
| seq_tx_done | input | 1 | Sequencer finished sending |
| seq_ready | input | 1 | Sequencer idle and ready |
| ctl_enable | output | 1 | Controller enable |
| ctl_master | output | 1 | Master mode select |
| clk_rate | output | 4 | Serial clock rate field |
| frame_start | output | 1 | One-cycle frame start pulse |
| total_bytes | output | 32 | Total bytes of the frame |
| cmd_bytes | output | 9 | Command byte count |
| multi_lane | output | 1 | Multi-lane enable |
| idle_cycles | output | 4 | Idle cycles |
| word_flag | output | 1 | Word-flag mode |

## Verification
The hardest case to reach is a partial queue, where a packed access finds one to three entries missing. The transmit queue is brought to 13 entries with three packed writes and one byte write. The receive queue is given three bytes and then read through the packed port. Each dropped access is then exposed by draining the queue byte by byte and comparing the order and count. A packed read with packing clear is checked the same way, followed by a byte read that must still return the oldest entry.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_FRAME = 8'h04;
  localparam logic [7:0] A_IEN   = 8'h0C;
  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_RXB   = 8'h40;
  localparam logic [7:0] A_TXB   = 8'h44;
  localparam logic [7:0] A_RXW   = 8'h48;
  localparam logic [7:0] A_TXW   = 8'h4C;
  localparam logic [7:0] A_UPPER = 8'h50;

  // true when 'need' more entries fit beside 'level' in a queue of 'depth'
  function automatic logic fits(input int unsigned level, input int unsigned need,
                                input int unsigned depth);
    return (level + need) <= depth;
  endfunction

  // sticky flag update: clear by write-one, set wins
  function automatic logic [2:0] flags_next(input logic [2:0] cur, input logic [2:0] set,
                                            input logic [2:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/host_byte_fifo.sv
module host_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANE_W-1:0]    push_n,
  input  logic [8*LANES-1:0]   push_data,
  input  logic [LANE_W-1:0]    pop_n,
  output logic [8*LANES-1:0]   peek_data,
  output logic [CNT_W-1:0]     level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (LANE_W'(i) < push_n) mem[wptr + PTR_W'(i)] <= push_data[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr + PTR_W'(push_n);
      rptr  <= rptr + PTR_W'(pop_n);
      level <= level + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_data[8*g +: 8] = mem[rptr + PTR_W'(g)];
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(level) + 32'(push_n)) <= (DEPTH + 32'(pop_n)));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pop_n) <= 32'(level));
endmodule

// File: rtl/spi_host_status.sv
module spi_host_status
  import spi_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] set_ev,
  input  logic [2:0] clr_ev,
  input  logic       tx_avail,
  input  logic       rx_empty,
  input  logic       tx_full,
  input  logic       ready,
  input  logic       packed_mode,
  input  logic [5:0] ien,
  output logic [8:0] status,
  output logic       irq
);
  logic [2:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_next(flags, set_ev, clr_ev);
  end

  assign status = {packed_mode, ready, 1'b0, tx_full, rx_empty, tx_avail, flags};
  assign irq    = |(status[5:0] & ien);

  // R9
  txdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[0] |=> status[0]);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev[0] && !set_ev[0]) |=> !status[0]);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LANES  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = $clog2(LANES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_empty,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  output logic        rx_full,
  input  logic        seq_tx_done,
  input  logic        seq_ready,
  output logic        ctl_enable,
  output logic        ctl_master,
  output logic [3:0]  clk_rate,
  output logic        frame_start,
  output logic [31:0] total_bytes,
  output logic [8:0]  cmd_bytes,
  output logic        multi_lane,
  output logic [3:0]  idle_cycles,
  output logic        word_flag
);
  logic        pack;
  logic [5:0]  ien;
  logic [15:0] upper_cnt, lower_cnt;
  logic [8:0]  status;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic [LANE_W-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [31:0] tx_push_data, tx_peek, rx_peek;
  logic        rx_accept, rd_rxb_ok, rd_rxw_ok;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_enable <= 1'b0; ctl_master <= 1'b0; pack <= 1'b0; clk_rate <= '0;
      ien <= '0; upper_cnt <= '0; lower_cnt <= '0; cmd_bytes <= '0;
      multi_lane <= 1'b0; idle_cycles <= '0; word_flag <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= wr_en && (addr == A_FRAME);
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            ctl_enable <= wdata[0]; ctl_master <= wdata[1];
            pack <= wdata[16]; clk_rate <= wdata[27:24];
          end
          A_IEN:   ien <= wdata[5:0];
          A_UPPER: upper_cnt <= wdata[31:16];
          A_FRAME: begin
            lower_cnt <= wdata[15:0]; cmd_bytes <= wdata[24:16];
            multi_lane <= wdata[25]; idle_cycles <= wdata[29:26];
            word_flag <= wdata[31];
          end
          default: ;
        endcase
      end
    end
  end

  assign total_bytes = {upper_cnt, lower_cnt};

  // transmit queue admission
  always_comb begin
    tx_push_n    = '0;
    tx_push_data = wdata;
    if (wr_en && addr == A_TXB && fits(32'(tx_level), 1, DEPTH)) begin
      tx_push_n    = LANE_W'(1);
      tx_push_data = {24'b0, wdata[7:0]};
    end else if (wr_en && addr == A_TXW && pack && fits(32'(tx_level), LANES, DEPTH)) begin
      tx_push_n = LANE_W'(LANES);
    end
  end
  assign tx_pop_n = (tx_pop && !tx_empty) ? LANE_W'(1) : '0;
  assign tx_empty = (tx_level == '0);
  assign tx_byte  = tx_peek[7:0];

  // receive queue admission
  assign rx_full   = (rx_level == CNT_W'(DEPTH));
  assign rx_accept = rx_push && !rx_full;
  assign rx_push_n = rx_accept ? LANE_W'(1) : '0;
  assign rd_rxb_ok = rd_en && addr == A_RXB && rx_level != '0;
  assign rd_rxw_ok = rd_en && addr == A_RXW && pack && (32'(rx_level) >= LANES);
  assign rx_pop_n  = rd_rxw_ok ? LANE_W'(LANES) : (rd_rxb_ok ? LANE_W'(1) : '0);

  host_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .peek_data(tx_peek), .level(tx_level));

  host_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_data({24'b0, rx_byte}),
    .pop_n(rx_pop_n), .peek_data(rx_peek), .level(rx_level));

  spi_host_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_ev({rx_accept, rx_accept && rx_last, seq_tx_done}),
    .clr_ev((wr_en && addr == A_STAT) ? wdata[2:0] : 3'b000),
    .tx_avail(tx_level != CNT_W'(DEPTH)), .rx_empty(rx_level == '0),
    .tx_full(tx_level == CNT_W'(DEPTH)), .ready(seq_ready), .packed_mode(pack),
    .ien(ien), .status(status), .irq(irq));

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {4'b0, clk_rate, 7'b0, pack, 14'b0, ctl_master, ctl_enable};
      A_FRAME: rdata = {word_flag, 1'b0, idle_cycles, multi_lane, cmd_bytes, lower_cnt};
      A_IEN:   rdata = {26'b0, ien};
      A_STAT:  rdata = {23'b0, status};
      A_UPPER: rdata = {upper_cnt, 16'b0};
      A_RXB:   if (rx_level != '0) rdata = {24'b0, rx_peek[7:0]};
      A_RXW:   if (rd_rxw_ok) rdata = rx_peek;
      default: rdata = '0;
    endcase
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
  // R3
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !(wr_en && addr == A_FRAME)) |=> !frame_start);
endmodule

// File: tb/spi_host_regs_tb.sv
module spi_host_regs_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, tx_pop = 0, tx_empty, rx_push = 0, rx_last = 0, rx_full;
  logic [7:0] tx_byte, rx_byte = 0;
  logic seq_tx_done = 0, seq_ready = 1;
  logic ctl_enable, ctl_master, frame_start, multi_lane, word_flag;
  logic [3:0] clk_rate, idle_cycles;
  logic [31:0] total_bytes;
  logic [8:0] cmd_bytes;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  spi_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_byte(rx_byte), .rx_last(rx_last),
    .rx_full(rx_full), .seq_tx_done(seq_tx_done), .seq_ready(seq_ready),
    .ctl_enable(ctl_enable), .ctl_master(ctl_master), .clk_rate(clk_rate),
    .frame_start(frame_start), .total_bytes(total_bytes), .cmd_bytes(cmd_bytes),
    .multi_lane(multi_lane), .idle_cycles(idle_cycles), .word_flag(word_flag));

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC [8] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0F01_0003},
    {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h0C, 32'h0,         32'h0000_003F},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'hBFFF_FFFF},
    {1'b1, 8'h50, 32'h1234_ABCD, 32'h0},
    {1'b0, 8'h50, 32'h0,         32'h1234_0000}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    @(negedge clk); chk(tag, {24'b0, tx_byte}, {24'b0, exp}); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic rx_in(input logic [7:0] b, input logic last);
    @(negedge clk); rx_push = 1; rx_byte = b; rx_last = last;
    @(negedge clk); rx_push = 0; rx_last = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(8'h00, rv); chk("R1 ctrl", rv, 0);
    bus_rd(8'h0C, rv); chk("R1 ien", rv, 0);
    bus_rd(8'h04, rv); chk("R1 frame", rv, 0);
    bus_rd(8'h10, rv); chk("R1 R8 status", rv, 32'h98);
    chk("R1 irq/frame_start/tx_empty", {irq, frame_start, tx_empty}, 3'b001);

    // R2 register table
    foreach (VEC[i]) begin
      if (VEC[i][72]) bus_wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][71:64], rv);
        chk("R2 readback", rv, VEC[i][31:0]);
      end
    end
    chk("R2 ctl outputs", {ctl_enable, ctl_master, clk_rate}, 6'h3F);
    chk("R3 total_bytes", total_bytes, 32'h1234_FFFF);

    // R3 frame start and fields
    bus_wr(8'h04, 32'h8C04_000A);
    chk("R3 frame_start", {31'b0, frame_start}, 1);
    chk("R3 fields", {cmd_bytes, idle_cycles, multi_lane, word_flag}, {9'd4, 4'd3, 1'b0, 1'b1});
    chk("R3 total", total_bytes, 32'h1234_000A);
    @(negedge clk); chk("R3 pulse width", {31'b0, frame_start}, 0);

    bus_wr(8'h00, 32'h0000_0003);
    bus_wr(8'h0C, 32'h0);
    // R5 packed write dropped with packing clear
    bus_wr(8'h4C, 32'hDEAD_BEEF);
    chk("R5 no pack drop", {31'b0, tx_empty}, 1);
    // R4 byte write
    bus_wr(8'h44, 32'h0000_01A5);
    chk("R4 not empty", {31'b0, tx_empty}, 0);
    pop_chk("R4 byte", 8'hA5);
    chk("R4 empty after pop", {31'b0, tx_empty}, 1);

    // R8 packing bit in status, R5 order
    bus_wr(8'h00, 32'h0001_0003);
    bus_rd(8'h10, rv); chk("R8 pack bit", rv & 32'h100, 32'h100);
    bus_wr(8'h4C, 32'h4433_2211);
    pop_chk("R5 lane0", 8'h11); pop_chk("R5 lane1", 8'h22);
    pop_chk("R5 lane2", 8'h33); pop_chk("R5 lane3", 8'h44);

    // R5 partial room: 13 entries, packed write dropped; R4 full drop
    bus_wr(8'h4C, 32'h0302_0100); bus_wr(8'h4C, 32'h0706_0504);
    bus_wr(8'h4C, 32'h0B0A_0908); bus_wr(8'h44, 32'h77);
    bus_wr(8'h4C, 32'hCCCC_CCCC);
    bus_rd(8'h10, rv); chk("R8 not full at 13", rv & 32'h28, 32'h08);
    bus_wr(8'h44, 32'h78); bus_wr(8'h44, 32'h79); bus_wr(8'h44, 32'h7A);
    bus_rd(8'h10, rv); chk("R8 full at 16", rv & 32'h28, 32'h20);
    bus_wr(8'h44, 32'h7B);
    for (int k = 0; k < 12; k++) pop_chk("R5 fill order", 8'(k));
    pop_chk("R4 byte 77", 8'h77); pop_chk("R4 byte 78", 8'h78);
    pop_chk("R4 byte 79", 8'h79); pop_chk("R4 byte 7A", 8'h7A);
    chk("R4 R5 drops left queue empty", {31'b0, tx_empty}, 1);

    // R7 partial receive, R6 byte read
    rx_in(8'h10, 0); rx_in(8'h11, 0); rx_in(8'h12, 0);
    bus_rd(8'h48, rv); chk("R7 short read zero", rv, 0);
    rx_in(8'h13, 0); rx_in(8'h14, 1);
    bus_rd(8'h48, rv); chk("R7 packed read", rv, 32'h1312_1110);
    bus_rd(8'h40, rv); chk("R6 byte read", rv, 32'h14);
    bus_rd(8'h40, rv); chk("R6 empty read", rv, 0);
    bus_rd(8'h10, rv); chk("R9 rx flags", rv, 32'h19E);

    // R10 masking, R9 write-one-clear
    chk("R10 irq masked", {31'b0, irq}, 0);
    bus_wr(8'h0C, 32'h02);
    chk("R10 irq rx_done", {31'b0, irq}, 1);
    bus_wr(8'h10, 32'h06);
    bus_rd(8'h10, rv); chk("R9 w1c rx", rv, 32'h198);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    @(negedge clk); seq_tx_done = 1; @(negedge clk); seq_tx_done = 0;
    bus_rd(8'h10, rv); chk("R9 tx_done set", rv & 32'h1, 1);
    bus_wr(8'h0C, 32'h01);
    chk("R10 irq tx_done", {31'b0, irq}, 1);
    bus_wr(8'h10, 32'h01);
    chk("R9 R10 tx_done cleared", {31'b0, irq}, 0);
    bus_wr(8'h0C, 32'h08);
    chk("R10 irq tx_avail", {31'b0, irq}, 1);

    // R7 packed read ignored with packing clear
    rx_in(8'h20, 0); rx_in(8'h21, 0); rx_in(8'h22, 0); rx_in(8'h23, 0);
    bus_wr(8'h00, 32'h0000_0003);
    bus_rd(8'h48, rv); chk("R7 no pack zero", rv, 0);
    bus_rd(8'h40, rv); chk("R7 no pop", rv, 32'h20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule